// File: doc/BRIEF.md
# Keyboard Interrupt Controller

This block watches a small port of active-low input pins and turns a press on any of them into an interrupt request. Each pin passes through a two-stage synchroniser. A pin takes part in detection only when its source-enable bit is set. A software-visible pending flag records each detection. An acknowledge write clears the flag. A separate mask gates the interrupt output without stopping detection, so software can still poll the flag while the interrupt is masked.

A mode bit chooses between two detection styles. In edge mode only a falling edge counts. In edge-plus-level mode a falling edge counts, and so does any enabled pin that stays low, so the flag comes back at once after an acknowledge while a key is still held. Writing the source-enable register clears the flag, which keeps a configuration change from causing a false trigger. A second per-pin mask selects which pins raise a wake-up request for leaving a stop state. A third register drives the enables of the pads' pull-up resistors.

Top module: `kbi_ctrl`

## Requirements
- R1: After reset the following are all zero: `irq_o`, `wake_o`, `pull_en`, `bus_rdata` and every register field.
- R2: A pin that goes low while its source bit is set is seen after two synchroniser stages. If the pin is driven low before clock edge k, the flag sets at edge k+2 and `irq_o` rises at edge k+3.
- R3: A pin whose source-enable bit is 0 never sets the flag, whatever it does.
- R4: In edge mode (CTRL bit0 = 0), writing 1 to the acknowledge bit (CTRL bit2) clears the flag. The flag then stays clear while the pin is held low, and only a new falling edge sets it again.
- R5: In edge-plus-level mode (CTRL bit0 = 1), the flag sets on every cycle in which any enabled synchronised pin is low. A set condition wins over an acknowledge written in the same cycle.
- R6: The mask bit (CTRL bit1) forces `irq_o` low but does not stop the flag from setting. `irq_o` equals flag AND NOT mask, registered one cycle later.
- R7: A write to the source-enable register (address 1) clears the flag on that edge. The clear wins over any detection in the same cycle.
- R8: `wake_o` is high one cycle after any synchronised pin is low whose wake-enable bit (address 2) is set. It does not depend on the mask or on the source-enable bits.
- R9: The pull-up register (address 3) drives `pull_en` directly from a register and reads back unchanged.
- R10: Register map for reads and writes:
  - Address 0 is CTRL: bit0 mode, bit1 mask, bit2 acknowledge (always reads 0), bit3 flag (read-only).
  - Addresses 1 to 3 hold per-pin bits in their low N_PINS bits.
  - `bus_rdata` is registered and shows the addressed register as it was before the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for `bus_addr` |
| pin_n | input | N_PINS | Active-low port inputs, asynchronous |
| pull_en | output | N_PINS | Pull-up enables to the pads |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-from-stop request |

## Verification
The checker tests the following rules on every cycle:
- every rise of the flag follows an enabled low pin;
- a source-enable write clears the flag;
- in edge mode the flag holds until it is acknowledged or cleared;
- `irq_o` only follows an unmasked flag;
- `wake_o` only follows a wake-enabled low pin.

Some behaviours can only be shown by the bench scenarios. These are the exact latency through the synchroniser, the absence of re-triggering on a held key in edge mode, and the immediate re-set after an acknowledge in level mode. The register readback values also depend on the scenarios, checked against a cycle-accurate reference model and directed expected values.

// File: rtl/kbi_pkg.sv
package kbi_pkg;
  typedef enum logic [1:0] {
    KA_CTRL = 2'd0,
    KA_SRC  = 2'd1,
    KA_WAKE = 2'd2,
    KA_PULL = 2'd3
  } kbi_addr_e;

  localparam int CB_MODE = 0;
  localparam int CB_MASK = 1;
  localparam int CB_ACK  = 2;
  localparam int CB_FLAG = 3;
endpackage

// File: rtl/kbi_sync.sv
module kbi_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '1;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '1;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/kbi_regs.sv
module kbi_regs
  import kbi_pkg::*;
#(
  parameter int N_PINS = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag,
  output logic              level_mode,
  output logic              mask,
  output logic              ack_p,
  output logic              src_wr_p,
  output logic [N_PINS-1:0] src_en,
  output logic [N_PINS-1:0] wake_en,
  output logic [N_PINS-1:0] pull_en,
  output logic [DATA_W-1:0] rdata
);
  kbi_addr_e a;
  logic [DATA_W-1:0] rd_mux;

  assign a        = kbi_addr_e'(addr);
  assign ack_p    = wr && (a == KA_CTRL) && wdata[CB_ACK];
  assign src_wr_p = wr && (a == KA_SRC);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_mode <= 1'b0;
      mask       <= 1'b0;
      src_en     <= '0;
      wake_en    <= '0;
      pull_en    <= '0;
    end else if (wr) begin
      case (a)
        KA_CTRL: begin
          level_mode <= wdata[CB_MODE];
          mask       <= wdata[CB_MASK];
        end
        KA_SRC:  src_en  <= wdata[N_PINS-1:0];
        KA_WAKE: wake_en <= wdata[N_PINS-1:0];
        KA_PULL: pull_en <= wdata[N_PINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (a)
      KA_CTRL: begin
        rd_mux[CB_MODE] = level_mode;
        rd_mux[CB_MASK] = mask;
        rd_mux[CB_FLAG] = flag;
      end
      KA_SRC:  rd_mux[N_PINS-1:0] = src_en;
      KA_WAKE: rd_mux[N_PINS-1:0] = wake_en;
      KA_PULL: rd_mux[N_PINS-1:0] = pull_en;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/kbi_detect.sv
module kbi_detect #(
  parameter int N_PINS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pins,
  input  logic [N_PINS-1:0] en,
  input  logic              level_mode,
  input  logic              ack,
  input  logic              cfg_clr,
  output logic              flag
);
  logic [N_PINS-1:0] prev;
  logic [N_PINS-1:0] fall;
  logic [N_PINS-1:0] low;
  logic              hit;

  assign fall = prev & ~pins & en;
  assign low  = ~pins & en;
  assign hit  = (|fall) | (level_mode & (|low));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '1;
      flag <= 1'b0;
    end else begin
      prev <= pins;
      if (cfg_clr) flag <= 1'b0;
      else         flag <= (flag & ~ack) | hit;
    end
  end
endmodule

// File: rtl/kbi_ctrl.sv
module kbi_ctrl
  import kbi_pkg::*;
#(
  parameter int N_PINS = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pin_n,
  output logic [N_PINS-1:0] pull_en,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int SYNC_STAGES = 2;

  logic [N_PINS-1:0] sync_pins;
  logic [N_PINS-1:0] src_en;
  logic [N_PINS-1:0] wake_en;
  logic              level_mode;
  logic              mask;
  logic              ack_p;
  logic              src_wr_p;
  logic              flag;

  kbi_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_n), .q(sync_pins)
  );

  kbi_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .flag(flag), .level_mode(level_mode), .mask(mask), .ack_p(ack_p),
    .src_wr_p(src_wr_p), .src_en(src_en), .wake_en(wake_en),
    .pull_en(pull_en), .rdata(bus_rdata)
  );

  kbi_detect #(.N_PINS(N_PINS)) u_det (
    .clk(clk), .rst(rst), .pins(sync_pins), .en(src_en),
    .level_mode(level_mode), .ack(ack_p), .cfg_clr(src_wr_p), .flag(flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= flag & ~mask;
      wake_o <= |(~sync_pins & wake_en);
    end
  end
endmodule

// File: rtl/kbi_ctrl_chk.sv
module kbi_ctrl_chk
  import kbi_pkg::*;
#(
  parameter int N_PINS = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              level_mode,
  input logic              mask,
  input logic              flag,
  input logic [N_PINS-1:0] sync_pins,
  input logic [N_PINS-1:0] src_en,
  input logic [N_PINS-1:0] wake_en,
  input logic              irq_o,
  input logic              wake_o
);
  logic wr_src, wr_ack;
  assign wr_src = bus_wr && (bus_addr == 2'd1);
  assign wr_ack = bus_wr && (bus_addr == 2'd0) && bus_wdata[CB_ACK];

  // R2 / R3: the flag only rises after an enabled pin was low
  a_r3_rise_needs_source: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(|(~sync_pins & src_en)));

  // R7: writing the source enables clears the flag
  a_r7_enable_clears: assert property (@(posedge clk) disable iff (rst)
    wr_src |=> !flag);

  // R4: in edge mode the flag holds until acknowledged or cleared
  a_r4_edge_sticky: assert property (@(posedge clk) disable iff (rst)
    (!level_mode && flag && !wr_ack && !wr_src) |=> flag);

  // R6: the interrupt only follows an unmasked flag
  a_r6_irq_unmasked: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(flag) && !$past(mask)));

  // R8: a wake request needs a wake-enabled low pin
  a_r8_wake_source: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(|(~sync_pins & wake_en)));
endmodule

bind kbi_ctrl kbi_ctrl_chk #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .level_mode(level_mode), .mask(mask), .flag(flag),
  .sync_pins(sync_pins), .src_en(src_en), .wake_en(wake_en),
  .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/sim_kbi_ctrl.sv
module sim_kbi_ctrl;
  localparam int N = 6;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0]  pin_n = '1;
  logic [N-1:0]  pull_en;
  logic          irq_o, wake_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  kbi_ctrl #(.N_PINS(N), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_n(pin_n),
    .pull_en(pull_en), .irq_o(irq_o), .wake_o(wake_o)
  );

  // behavioural reference, advanced on every rising edge
  int m_s1, m_s2, m_prev, m_src, m_wk, m_pull;
  int m_lvl, m_msk, m_flag, m_irq, m_wake, m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = '1; m_s2 = '1; m_prev = '1;
      m_src = 0; m_wk = 0; m_pull = 0;
      m_lvl = 0; m_msk = 0; m_flag = 0; m_irq = 0; m_wake = 0; m_rd = 0;
    end else begin
      int hit, nwake, nflag, rd;
      hit = 0; nwake = 0;
      for (int i = 0; i < N; i++) begin
        if (m_src[i] && !m_s2[i] && (m_prev[i] || m_lvl != 0)) hit = 1;
        if (m_wk[i] && !m_s2[i]) nwake = 1;
      end
      case (bus_addr)
        2'd0: rd = m_lvl + 2 * m_msk + 8 * m_flag;
        2'd1: rd = m_src;
        2'd2: rd = m_wk;
        default: rd = m_pull;
      endcase
      if (bus_wr && bus_addr == 2'd1) nflag = 0;
      else nflag = ((m_flag != 0 && !(bus_wr && bus_addr == 2'd0 && bus_wdata[2])) || hit != 0) ? 1 : 0;
      m_irq  = (m_flag != 0 && m_msk == 0) ? 1 : 0;
      m_wake = nwake;
      m_rd   = rd;
      m_flag = nflag;
      if (bus_wr) begin
        case (bus_addr)
          2'd0: begin m_lvl = bus_wdata[0]; m_msk = bus_wdata[1]; end
          2'd1: m_src  = bus_wdata[N-1:0];
          2'd2: m_wk   = bus_wdata[N-1:0];
          default: m_pull = bus_wdata[N-1:0];
        endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_n;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, away from the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 irq model", irq_o, m_irq);
      chk("R8 wake model", wake_o, m_wake);
      chk("R9 pull model", pull_en, m_pull);
      chk("R10 rdata model", bus_rdata, m_rd);
    end
  end

  task automatic wr(input int a, input int d);
    bus_wr = 1'b1; bus_addr = a[1:0]; bus_wdata = d[DW-1:0];
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    bus_addr = a[1:0];
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 wake", wake_o, 0);
    chk("R1 pull", pull_en, 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 src", v, 0);

    wr(1, 'h05);
    // R3: pin1 not enabled
    pin_n[1] = 1'b0; idle(6);
    rd(0, v); chk("R3 disabled pin", v, 'h00);
    chk("R3 irq", irq_o, 0);
    pin_n[1] = 1'b1; idle(3);

    // R2: latency through the synchroniser
    pin_n[0] = 1'b0;
    idle(3); chk("R2 irq before edge k+3", irq_o, 0);
    idle(1); chk("R2 irq at edge k+3", irq_o, 1);
    rd(0, v); chk("R2 flag", v, 'h08);
    // R4: acknowledge in edge mode, key still held
    wr(0, 'h04); idle(4);
    rd(0, v); chk("R4 ack clears held key", v, 'h00);
    chk("R4 irq low", irq_o, 0);

    // R6: masked detection still sets the flag
    wr(0, 'h02);
    pin_n[0] = 1'b1; idle(4);
    pin_n[2] = 1'b0; idle(6);
    rd(0, v); chk("R6 masked flag", v, 'h0A);
    chk("R6 irq masked", irq_o, 0);
    wr(0, 'h00); idle(2);
    chk("R6 irq after unmask", irq_o, 1);

    // R5: level mode, ack with key still low
    wr(0, 'h05); idle(2);
    rd(0, v); chk("R5 re-set after ack", v, 'h09);
    pin_n[2] = 1'b1; idle(4);
    wr(0, 'h05); idle(2);
    rd(0, v); chk("R5 clear after release", v, 'h01);

    // R7: enable write clears flag (edge mode, key held)
    wr(0, 'h04);
    pin_n[0] = 1'b0; idle(5);
    rd(0, v); chk("R7 flag before", v, 'h08);
    wr(1, 'h05); idle(2);
    rd(0, v); chk("R7 enable write clears", v, 'h00);
    pin_n[0] = 1'b1; idle(4);

    // R8: wake from a pin that is not an interrupt source
    wr(2, 'h08);
    pin_n[3] = 1'b0; idle(4);
    chk("R8 wake high", wake_o, 1);
    rd(0, v); chk("R8 no flag from wake-only pin", v, 'h00);
    pin_n[3] = 1'b1; idle(4);
    chk("R8 wake low", wake_o, 0);

    // R9 / R10 register readback
    wr(3, 'h2A);
    chk("R9 pull output", pull_en, 'h2A);
    rd(3, v); chk("R9 pull readback", v, 'h2A);
    rd(1, v); chk("R10 src readback", v, 'h05);
    rd(2, v); chk("R10 wake readback", v, 'h08);
    wr(0, 'h07); idle(1);
    rd(0, v); chk("R10 ack reads zero", v & 'h07, 'h03);

    // mixed traffic, compared every cycle against the reference
    for (int k = 0; k < 600; k++) begin
      pin_n = $urandom_range(0, 63);
      if ($urandom_range(0, 5) == 0) wr($urandom_range(0, 3), $urandom_range(0, 255));
      else begin bus_addr = $urandom_range(0, 3); idle(1); end
    end

    idle(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule